// File: doc/BRIEF.md
# DMA Bus Ownership Arbiter

This block decides which DMA requester may use the system bus and for how long. A configuration input selects one of two layouts. In the split layout there are four narrow-address requesters. In the wide layout there are two full-address channels. The block raises a bus request while any eligible requester is waiting. When the bus grant arrives, it takes the highest-priority requester present in that cycle and holds that choice until a release point.

Each requester has a two-bit transfer style, which sets when the bus is handed back. A per-unit style hands the bus back after every byte or word. Burst and block styles keep the bus until the transfer engine reports the end of the run. A waiting requester of higher rank can end a burst or block early at a unit boundary. So can a request from a higher-priority bus master. After a release the block drops its request for one cycle. It then asks again if work is still pending.

Top module: `dma_bus_arbiter`

## Requirements
- R1: In split layout (`split_mode_i`=1) the requesters are `req_i` bits 0,1,2,3, and bit 0 has the highest priority and bit 3 the lowest. `owner_o` is one-hot, with bit k set for requester k.
- R2: In wide layout (`split_mode_i`=0) only `req_i[0]` (channel 0, higher) and `req_i[1]` (channel 1) are eligible, and `req_i[3:2]` are ignored. The owner shows on `owner_o[0]` or `owner_o[1]`.
- R3: From idle, `bus_req_o` rises in the cycle after an eligible request is seen. It stays low while no request is eligible.
- R4: On a cycle where `bus_gnt_i` is high while `bus_req_o` is high and no owner is held, the highest-priority eligible requester of that cycle becomes the owner. It appears on `owner_o` in the next cycle.
- R5: While the bus is held, `owner_o` does not change, whatever other requests arrive.
- R6: In split layout, or in wide layout with style code 00 or 11, a `unit_done_i` pulse releases the bus. In the next cycle `bus_req_o` and `owner_o` are both zero.
- R7: With style 01 (burst) or 10 (block), `unit_done_i` alone keeps the bus. A `run_done_i` pulse releases it.
- R8: During burst or block, `unit_done_i` releases the bus if, in the same cycle, a higher-priority eligible requester waits or `master_req_i` is high. A waiting lower-priority requester does not cause a release.
- R9: After a release, `bus_req_o` stays low for exactly one cycle, then rises again if an eligible request remains.
- R10: If no eligible request remains in the grant cycle, no owner is taken and the block returns to idle.
- R11: Synchronous active-high `rst` clears `bus_req_o` and `owner_o`.
- R12: The layout is sampled only while idle. A change of `split_mode_i` while the bus is requested or held takes effect after release.
- R13: Style codes are 2 bits per requester, in `xfer_style_i[2k+1:2k]` for requester k: 00 single, 01 burst, 10 block, 11 cycle-steal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| split_mode_i | input | 1 | 1: four requesters, 0: two channels |
| req_i | input | 4 | Level request per requester |
| xfer_style_i | input | 8 | 2-bit transfer style per requester |
| master_req_i | input | 1 | Bus request from a higher-priority master |
| unit_done_i | input | 1 | One byte or word finished |
| run_done_i | input | 1 | Burst or block finished |
| bus_gnt_i | input | 1 | Bus grant |
| bus_req_o | output | 1 | Bus request |
| owner_o | output | 4 | One-hot active requester, zero when not held |

## Verification
A wrong owner latch shows on `owner_o` in the first cycle after the grant. Corruption while the bus is held shows in the next cycle, as a change of `owner_o` without a release. A faulty release decision shows one cycle after the `unit_done_i` or `run_done_i` pulse, as `bus_req_o` staying high or dropping when it should not. A stale layout register shows at the next grant, as a wrong priority or as an ignored bit being selected.

// File: rtl/dab_pkg.sv
package dab_pkg;
  localparam int NREQ = 4;
  localparam int NWIDE = NREQ / 2;
  localparam int SW = 2;

  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_ASK = 2'd1, ST_HOLD = 2'd2} arb_st_t;

  localparam logic [SW-1:0] STY_SINGLE = 2'b00;
  localparam logic [SW-1:0] STY_BURST  = 2'b01;
  localparam logic [SW-1:0] STY_BLOCK  = 2'b10;
  localparam logic [SW-1:0] STY_STEAL  = 2'b11;

  function automatic logic [NREQ-1:0] eligible(input logic [NREQ-1:0] req, input logic split);
    logic [NREQ-1:0] wmask;
    wmask = '0;
    wmask[NWIDE-1:0] = '1;
    return split ? req : (req & wmask);
  endfunction

  function automatic logic holds_run(input logic [SW-1:0] sty);
    return (sty == STY_BURST) || (sty == STY_BLOCK);
  endfunction
endpackage

// File: rtl/dab_pick.sv
module dab_pick
  import dab_pkg::*;
#(
  parameter int N = NREQ
) (
  input  logic [N-1:0] elig,
  output logic [N-1:0] pick
);
  logic [N-1:0] seen;

  generate
    for (genvar k = 0; k < N; k++) begin : g_rank
      if (k == 0) begin : g_top
        assign pick[k] = elig[k];
        assign seen[k] = elig[k];
      end else begin : g_rest
        assign pick[k] = elig[k] & ~seen[k-1];
        assign seen[k] = elig[k] | seen[k-1];
      end
    end
  endgenerate

  always_comb begin
    // R1
    pick_onehot_chk: assert ($onehot0(pick));
  end
endmodule

// File: rtl/dab_release.sv
module dab_release
  import dab_pkg::*;
#(
  parameter int N = NREQ
) (
  input  logic [N-1:0]    owner,
  input  logic            split,
  input  logic [N*SW-1:0] styles,
  input  logic [N-1:0]    elig,
  input  logic            master_req,
  input  logic            unit_done,
  input  logic            run_done,
  output logic            per_unit,
  output logic            preempt,
  output logic            release_now
);
  logic [SW-1:0] own_sty;
  logic [N-1:0]  above;

  always_comb begin
    own_sty = '0;
    for (int k = 0; k < N; k++)
      if (owner[k]) own_sty = styles[k*SW +: SW];
  end

  assign above       = owner - 1'b1;
  assign per_unit    = split || !holds_run(own_sty);
  assign preempt     = master_req || (|(elig & above));
  assign release_now = (|owner) && (per_unit ? unit_done
                                             : (run_done || (unit_done && preempt)));
endmodule

// File: rtl/dma_bus_arbiter.sv
module dma_bus_arbiter
  import dab_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              split_mode_i,
  input  logic [NREQ-1:0]   req_i,
  input  logic [NREQ*SW-1:0] xfer_style_i,
  input  logic              master_req_i,
  input  logic              unit_done_i,
  input  logic              run_done_i,
  input  logic              bus_gnt_i,
  output logic              bus_req_o,
  output logic [NREQ-1:0]   owner_o
);
  arb_st_t          st;
  logic             split_q;
  logic [NREQ-1:0]  owner_q;
  logic             cur_split;
  logic [NREQ-1:0]  elig_w;
  logic [NREQ-1:0]  pick_w;
  logic             any_w;
  logic             held_w;
  logic             per_unit_w;
  logic             preempt_w;
  logic             rel_w;

  assign cur_split = (st == ST_IDLE) ? split_mode_i : split_q;
  assign elig_w    = eligible(req_i, cur_split);
  assign any_w     = |elig_w;
  assign held_w    = (st == ST_HOLD);

  dab_pick #(.N(NREQ)) u_pick (.elig(elig_w), .pick(pick_w));

  dab_release #(.N(NREQ)) u_rel (
    .owner(owner_q), .split(split_q), .styles(xfer_style_i), .elig(elig_w),
    .master_req(master_req_i), .unit_done(unit_done_i), .run_done(run_done_i),
    .per_unit(per_unit_w), .preempt(preempt_w), .release_now(rel_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      owner_q <= '0;
      split_q <= split_mode_i;
    end else begin
      case (st)
        ST_IDLE: begin
          split_q <= split_mode_i;
          if (any_w) st <= ST_ASK;
        end
        ST_ASK: begin
          if (bus_gnt_i) begin
            if (any_w) begin
              st      <= ST_HOLD;
              owner_q <= pick_w;
            end else begin
              st <= ST_IDLE;
            end
          end
        end
        ST_HOLD: begin
          if (rel_w) begin
            st      <= ST_IDLE;
            owner_q <= '0;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign bus_req_o = (st != ST_IDLE);
  assign owner_o   = held_w ? owner_q : '0;

  // R1
  owner_onehot_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(owner_o));
  // R5
  owner_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (held_w && !rel_w) |=> (owner_o == $past(owner_o)));
  // R6
  release_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (held_w && rel_w) |=> (!bus_req_o && owner_o == '0));
  // R3
  req_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && !any_w) |=> !bus_req_o);
  // R12
  layout_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (st != ST_IDLE) |=> $stable(split_q));
  // R8
  burst_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (held_w && !per_unit_w && !run_done_i && !preempt_w) |=> bus_req_o);
endmodule

// File: tb/tb_dma_bus_arbiter.sv
module tb_dma_bus_arbiter;
  logic       clk = 1'b0;
  logic       rst;
  logic       split_mode_i;
  logic [3:0] req_i;
  logic [7:0] xfer_style_i;
  logic       master_req_i, unit_done_i, run_done_i, bus_gnt_i;
  logic       bus_req_o;
  logic [3:0] owner_o;

  int n_chk = 0;
  int n_bad = 0;
  bit rnd_on = 1'b0;

  always #2 clk = ~clk;

  dma_bus_arbiter dut (
    .clk(clk), .rst(rst), .split_mode_i(split_mode_i), .req_i(req_i),
    .xfer_style_i(xfer_style_i), .master_req_i(master_req_i),
    .unit_done_i(unit_done_i), .run_done_i(run_done_i), .bus_gnt_i(bus_gnt_i),
    .bus_req_o(bus_req_o), .owner_o(owner_o)
  );

  // reference model, written from the requirements
  int         m_st;
  logic       m_split;
  logic [3:0] m_own;

  function automatic logic [3:0] m_elig(logic [3:0] r, logic sp);
    return sp ? r : {2'b00, r[1:0]};
  endfunction

  function automatic logic [3:0] m_first(logic [3:0] e);
    if (e[0]) return 4'b0001;
    if (e[1]) return 4'b0010;
    if (e[2]) return 4'b0100;
    if (e[3]) return 4'b1000;
    return 4'b0000;
  endfunction

  function automatic logic m_free(logic [3:0] own, logic sp, logic [7:0] sty, logic [3:0] e,
                                  logic mr, logic ud, logic rd);
    logic [1:0] s;
    logic hi;
    case (own)
      4'b0001: begin s = sty[1:0]; hi = 1'b0;   end
      4'b0010: begin s = sty[3:2]; hi = e[0];   end
      4'b0100: begin s = sty[5:4]; hi = |e[1:0]; end
      default: begin s = sty[7:6]; hi = |e[2:0]; end
    endcase
    if (sp || s == 2'b00 || s == 2'b11) return ud;
    return rd || (ud && (mr || hi));
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_st <= 0; m_own <= 4'b0; m_split <= split_mode_i;
    end else begin
      case (m_st)
        0: begin
          m_split <= split_mode_i;
          if (m_elig(req_i, split_mode_i) != 0) m_st <= 1;
        end
        1: if (bus_gnt_i) begin
          if (m_elig(req_i, m_split) != 0) begin
            m_st <= 2; m_own <= m_first(m_elig(req_i, m_split));
          end else m_st <= 0;
        end
        default: if (m_free(m_own, m_split, xfer_style_i, m_elig(req_i, m_split),
                            master_req_i, unit_done_i, run_done_i)) begin
          m_st <= 0; m_own <= 4'b0;
        end
      endcase
    end
  end

  task automatic chk(string tag, logic exp_req, logic [3:0] exp_own);
    n_chk++;
    if (bus_req_o !== exp_req || owner_o !== exp_own) begin
      n_bad++;
      $display("FAIL %s: bus_req=%0b owner=%b, expected bus_req=%0b owner=%b",
               tag, bus_req_o, owner_o, exp_req, exp_own);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_unit();
    unit_done_i = 1'b1; step(); unit_done_i = 1'b0;
  endtask

  task automatic grant();
    bus_gnt_i = 1'b1; step(); bus_gnt_i = 1'b0;
  endtask

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  always @(negedge clk) if (rnd_on) chk("R4/R5 random", m_st != 0, (m_st == 2) ? m_own : 4'b0);

  initial begin
    rst = 1'b1; split_mode_i = 1'b1; req_i = 4'b0; xfer_style_i = 8'h00;
    master_req_i = 1'b0; unit_done_i = 1'b0; run_done_i = 1'b0; bus_gnt_i = 1'b0;
    step(); step();
    chk("R11 reset", 1'b0, 4'b0000);
    rst = 1'b0; step();
    chk("R3 idle without request", 1'b0, 4'b0000);

    // split layout priority and per-unit release (style burst ignored)
    xfer_style_i = 8'h55;
    req_i = 4'b1110; step();
    chk("R3 request rises", 1'b1, 4'b0000);
    grant();
    chk("R1 split priority", 1'b1, 4'b0010);
    req_i = 4'b1111; step();
    chk("R5 owner held", 1'b1, 4'b0010);
    pulse_unit();
    chk("R6 split per-unit release", 1'b0, 4'b0000);
    step();
    chk("R9 re-request", 1'b1, 4'b0000);
    grant();
    chk("R4 new owner", 1'b1, 4'b0001);
    req_i = 4'b0000; pulse_unit(); step();
    chk("R3 stays idle", 1'b0, 4'b0000);

    // wide layout
    split_mode_i = 1'b0; step();
    req_i = 4'b1100; step();
    chk("R2 upper bits ignored", 1'b0, 4'b0000);
    req_i = 4'b1110; step(); grant();
    chk("R2 channel 1 owner", 1'b1, 4'b0010);
    // R13: channel 1 burst (01)
    xfer_style_i = 8'b0000_0100;
    pulse_unit();
    chk("R7 burst keeps bus", 1'b1, 4'b0010);
    req_i = 4'b0011; pulse_unit();
    chk("R8 higher channel preempts", 1'b0, 4'b0000);
    step(); grant();
    chk("R1 channel 0 wins", 1'b1, 4'b0001);
    xfer_style_i = 8'b0000_0010;  // channel 0 block
    pulse_unit();
    chk("R8 lower channel no preempt", 1'b1, 4'b0001);
    master_req_i = 1'b1; pulse_unit(); master_req_i = 1'b0;
    chk("R8 master preempts", 1'b0, 4'b0000);
    step(); grant();
    run_done_i = 1'b1; step(); run_done_i = 1'b0;
    chk("R7 run end releases", 1'b0, 4'b0000);
    xfer_style_i = 8'b0000_0011;  // cycle-steal
    step(); grant(); pulse_unit();
    chk("R6 steal per-unit release", 1'b0, 4'b0000);

    // dropped request before grant
    step();
    req_i = 4'b0000; grant();
    chk("R10 nothing taken", 1'b0, 4'b0000);

    // layout change while held
    req_i = 4'b0010; xfer_style_i = 8'b0000_0100; step(); grant();
    split_mode_i = 1'b1; req_i = 4'b0110; pulse_unit();
    chk("R12 layout frozen while held", 1'b1, 4'b0010);
    req_i = 4'b0100; run_done_i = 1'b1; step(); run_done_i = 1'b0;
    step(); grant();
    chk("R12 new layout after release", 1'b1, 4'b0100);
    pulse_unit();

    // constrained random against the model
    rst = 1'b1; step(); rst = 1'b0;
    rnd_on = 1'b1;
    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      req_i        = $urandom % 16;
      xfer_style_i = $urandom;
      master_req_i = ($urandom % 8) == 0;
      unit_done_i  = ($urandom % 3) == 0;
      run_done_i   = ($urandom % 10) == 0;
      bus_gnt_i    = ($urandom % 2) == 0;
      if (($urandom % 40) == 0) split_mode_i = ~split_mode_i;
      @(posedge clk);
      @(negedge clk);
    end
    rnd_on = 1'b0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule